// File: doc/BRIEF.md
# Sleep Mode Power Sequencer

This block sequences the low-power states of a small microcontroller core. Software holds a sleep enable bit and a 3-bit mode code in a configuration register. When the core executes its sleep instruction with the enable bit set, the block latches the chosen mode. It then drops the clock enables of the CPU, flash, I/O, ADC and asynchronous-timer domains as that mode dictates, and may also stop the main and asynchronous oscillators.

While the core is asleep, the block compares a vector of ten wake sources against a mask that belongs to the latched mode. A qualifying source, or a reset request, starts the wake sequence. If the latched mode had stopped the main oscillator, the block first waits a programmable start-up count. It then holds the core for a fixed four-cycle halt. Finally it raises a one-cycle resume strobe, with a flag that tells the core whether to take the reset vector or the interrupt path back to the instruction after the sleep.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset the block is awake: every clock enable and both oscillator enables are 1, and `asleep`, `core_stall` and `resume_valid` are 0.
- R2: A `sleep_req` pulse while the stored sleep enable bit is 0 has no effect. `asleep` stays 0 and every clock enable stays 1.
- R3: A `sleep_req` pulse while the stored enable bit is 1 raises `asleep` one cycle later. While `asleep` is high, the CPU and flash clock enables are 0.
- R4: While asleep, the enables {cpu,flash,io,adc,async,main_osc,async_osc} follow the mode code, where a = `timer2_async`:
  - 000 Idle gives 0011111.
  - 001 ADC noise reduction gives 0001111.
  - 010 power-down gives 0000000.
  - 011 power-save gives 0000a0a.
  - 110 standby gives 0000010.
  - 111 extended standby gives 0000a1a.
- R5: The reserved mode codes 100 and 101 behave exactly like Idle, for both clock gating and wake sources.
- R6: The wake-source bits are: 0 external interrupt, level-sensitive; 1 external interrupt, edge-sensitive; 2 pin change; 3 two-wire address match; 4 Timer2; 5 NVM ready; 6 ADC complete; 7 watchdog; 8 UART start frame; 9 other I/O. Idle accepts all ten sources. ADC noise reduction accepts bits 0, 2, 3, 5, 6 and 7. Power-down and standby accept bits 0, 2, 3, 7 and 8. Power-save and extended standby accept the same set as power-down. A source outside the mask leaves the core asleep.
- R7: The edge-sensitive external interrupt (bit 1) wakes the core only from Idle. The level-sensitive one (bit 0) wakes it from every mode.
- R8: Timer2 (bit 4) wakes the core from ADC noise reduction, power-save and extended standby only while `timer2_async` is 1.
- R9: After wake, `core_stall` stays high with `asleep` low for S+4 cycles when the latched mode is power-down or power-save. Here S is `startup_cycles`. In all other modes it stays high for exactly 4 cycles.
- R10: The wake sequence ends with `resume_valid` high for exactly one cycle. In that cycle `core_stall` is 0 and every enable is 1. `resume_reset` is 0 when only an interrupt caused the wake.
- R11: A `wake_reset` seen while asleep, during start-up or during the halt makes `resume_reset` 1 in the resume cycle. This holds even when an interrupt arrives at the same time.
- R12: The mode is latched when sleep is entered. A configuration write while asleep changes neither the gating nor the start-up length of the current sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_sleep_en | input | 1 | Sleep enable bit written on `cfg_wr` |
| cfg_mode | input | 3 | Mode code written on `cfg_wr` |
| sleep_req | input | 1 | Core is executing its sleep instruction |
| wake_src | input | 10 | Wake source requests, bit layout in R6 |
| timer2_async | input | 1 | Timer2 runs from its own oscillator |
| wake_reset | input | 1 | Reset request from a reset source |
| startup_cycles | input | STARTUP_W | Oscillator start-up wait in cycles |
| cpu_clk_en | output | 1 | CPU clock domain enable |
| flash_clk_en | output | 1 | Flash clock domain enable |
| io_clk_en | output | 1 | I/O clock domain enable |
| adc_clk_en | output | 1 | ADC clock domain enable |
| async_clk_en | output | 1 | Asynchronous timer clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| async_osc_en | output | 1 | Asynchronous timer oscillator enable |
| asleep | output | 1 | Core is in a sleep mode |
| core_stall | output | 1 | Core must not execute |
| resume_valid | output | 1 | One-cycle strobe ending the wake sequence |
| resume_reset | output | 1 | With `resume_valid`: 1 selects the reset vector, 0 the interrupt path |

## Verification
The assertions check on every cycle the local rules of the sequencer:
- a disabled sleep request leaves the core running;
- an unmasked-free cycle keeps it asleep;
- a reset request is remembered;
- the halt ends in a single resume cycle;
- the core clocks are off while asleep;
- the main oscillator runs whenever the core is stalled but awake.

Only the bench's sweeps can show the full per-mode tables. The sweeps cover every mode code with both Timer2 settings and every single wake source. They also show the exact stall lengths with and without start-up, the reset-vector choice, and that a mid-sleep configuration write is ignored.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    localparam int NUM_WAKE = 10;

    // wake source bit positions
    localparam int WK_EXT_LVL  = 0;
    localparam int WK_EXT_EDGE = 1;
    localparam int WK_PIN_CHG  = 2;
    localparam int WK_TWI      = 3;
    localparam int WK_TIMER2   = 4;
    localparam int WK_NVM      = 5;
    localparam int WK_ADC      = 6;
    localparam int WK_WDOG     = 7;
    localparam int WK_UART     = 8;
    localparam int WK_OTHER_IO = 9;

    typedef enum logic [2:0] {
        M_IDLE  = 3'b000,
        M_ADCNR = 3'b001,
        M_PDOWN = 3'b010,
        M_PSAVE = 3'b011,
        M_RSV4  = 3'b100,
        M_RSV5  = 3'b101,
        M_STBY  = 3'b110,
        M_XSTBY = 3'b111
    } slp_mode_e;

    typedef enum logic [2:0] {
        PH_RUN,
        PH_SLEEP,
        PH_STARTUP,
        PH_HALT,
        PH_RESUME
    } phase_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic async_t;
        logic osc_main;
        logic osc_async;
    } clk_plan_t;

    localparam clk_plan_t PLAN_ALL_ON = '{default: 1'b1};

    // reserved codes fold onto Idle
    function automatic slp_mode_e fold_mode(input logic [2:0] code);
        slp_mode_e m;
        case (code)
            3'b001:  m = M_ADCNR;
            3'b010:  m = M_PDOWN;
            3'b011:  m = M_PSAVE;
            3'b110:  m = M_STBY;
            3'b111:  m = M_XSTBY;
            default: m = M_IDLE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
    import pwr_sleep_pkg::*;
(
    input  slp_mode_e              mode,
    input  logic                   timer2_async,
    output clk_plan_t              plan,
    output logic [NUM_WAKE-1:0]    mask,
    output logic                   osc_restart
);

    always_comb begin
        plan        = '0;
        mask        = '0;
        osc_restart = 1'b0;
        // sources that survive every mode
        mask[WK_EXT_LVL] = 1'b1;
        mask[WK_PIN_CHG] = 1'b1;
        mask[WK_TWI]     = 1'b1;
        mask[WK_WDOG]    = 1'b1;
        case (mode)
            M_ADCNR: begin
                plan.adc       = 1'b1;
                plan.async_t   = 1'b1;
                plan.osc_main  = 1'b1;
                plan.osc_async = 1'b1;
                mask[WK_NVM]    = 1'b1;
                mask[WK_ADC]    = 1'b1;
                mask[WK_TIMER2] = timer2_async;
            end
            M_PDOWN: begin
                osc_restart    = 1'b1;
                mask[WK_UART]  = 1'b1;
            end
            M_PSAVE: begin
                osc_restart     = 1'b1;
                plan.async_t    = timer2_async;
                plan.osc_async  = timer2_async;
                mask[WK_UART]   = 1'b1;
                mask[WK_TIMER2] = timer2_async;
            end
            M_STBY: begin
                plan.osc_main  = 1'b1;
                mask[WK_UART]  = 1'b1;
            end
            M_XSTBY: begin
                plan.osc_main   = 1'b1;
                plan.async_t    = timer2_async;
                plan.osc_async  = timer2_async;
                mask[WK_UART]   = 1'b1;
                mask[WK_TIMER2] = timer2_async;
            end
            default: begin
                plan.io        = 1'b1;
                plan.adc       = 1'b1;
                plan.async_t   = 1'b1;
                plan.osc_main  = 1'b1;
                plan.osc_async = 1'b1;
                mask           = '1;
            end
        endcase
    end

endmodule

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter
    import pwr_sleep_pkg::*;
(
    input  logic [NUM_WAKE-1:0] src,
    input  logic [NUM_WAKE-1:0] mask,
    output logic                wake_hit
);

    logic [NUM_WAKE-1:0] qualified;

    for (genvar i = 0; i < NUM_WAKE; i++) begin : g_qual
        assign qualified[i] = src[i] & mask[i];
    end

    assign wake_hit = |qualified;

endmodule

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq
    import pwr_sleep_pkg::*;
#(
    parameter int STARTUP_W   = 16,
    parameter int HALT_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sleep_req,
    input  logic                 sleep_en,
    input  slp_mode_e            mode_in,
    input  logic                 wake_hit,
    input  logic                 wake_reset,
    input  logic                 osc_restart,
    input  logic [STARTUP_W-1:0] startup_cycles,
    output phase_e               phase,
    output slp_mode_e            mode_lat,
    output logic                 rst_seen
);

    localparam int HALT_W = $clog2(HALT_CYCLES + 1);
    localparam int CNT_W  = (STARTUP_W > HALT_W) ? STARTUP_W : HALT_W;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        slp_mode_e        mode;
        logic             rst;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        case (q.phase)
            PH_RUN: begin
                if (sleep_req && sleep_en) begin
                    d.phase = PH_SLEEP;
                    d.mode  = mode_in;
                    d.rst   = 1'b0;
                end
            end
            PH_SLEEP: begin
                if (wake_hit || wake_reset) begin
                    d.rst = wake_reset;
                    if (osc_restart && (startup_cycles != '0)) begin
                        d.phase = PH_STARTUP;
                        d.cnt   = CNT_W'(startup_cycles - 1'b1);
                    end else begin
                        d.phase = PH_HALT;
                        d.cnt   = CNT_W'(HALT_CYCLES - 1);
                    end
                end
            end
            PH_STARTUP: begin
                d.rst = q.rst | wake_reset;
                if (q.cnt == '0) begin
                    d.phase = PH_HALT;
                    d.cnt   = CNT_W'(HALT_CYCLES - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_HALT: begin
                d.rst = q.rst | wake_reset;
                if (q.cnt == '0) begin
                    d.phase = PH_RESUME;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: begin
                d.phase = PH_RUN;
                d.rst   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= PH_RUN;
            q.cnt   <= '0;
            q.mode  <= M_IDLE;
            q.rst   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign phase    = q.phase;
    assign mode_lat = q.mode;
    assign rst_seen = q.rst;

    // R2: sleep with enable clear is a no-op
    a_r2_disabled_sleep_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_RUN && sleep_req && !sleep_en) |=> (q.phase == PH_RUN));

    // R6: nothing qualifying keeps the core asleep
    a_r6_no_wake_stays_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_SLEEP && !wake_hit && !wake_reset) |=> (q.phase == PH_SLEEP));

    // R11: a reset request during sleep or wake is remembered
    a_r11_reset_remembered: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.phase == PH_SLEEP || q.phase == PH_STARTUP || q.phase == PH_HALT) && wake_reset)
        |=> q.rst);

    // R9: the last halt cycle leads to resume
    a_r9_halt_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_HALT && q.cnt == '0) |=> (q.phase == PH_RESUME));

    // R10: resume lasts one cycle
    a_r10_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_RESUME) |=> (q.phase == PH_RUN));

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int STARTUP_W   = 16,
    parameter int HALT_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic                 cfg_sleep_en,
    input  logic [2:0]           cfg_mode,
    input  logic                 sleep_req,
    input  logic [9:0]           wake_src,
    input  logic                 timer2_async,
    input  logic                 wake_reset,
    input  logic [STARTUP_W-1:0] startup_cycles,
    output logic                 cpu_clk_en,
    output logic                 flash_clk_en,
    output logic                 io_clk_en,
    output logic                 adc_clk_en,
    output logic                 async_clk_en,
    output logic                 main_osc_en,
    output logic                 async_osc_en,
    output logic                 asleep,
    output logic                 core_stall,
    output logic                 resume_valid,
    output logic                 resume_reset
);

    typedef struct packed {
        logic       sleep_en;
        logic [2:0] mode;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d.sleep_en = cfg_sleep_en;
            cfg_d.mode     = cfg_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    phase_e              phase;
    slp_mode_e           mode_lat;
    logic                rst_seen;
    clk_plan_t           plan;
    logic [NUM_WAKE-1:0] mask;
    logic                osc_restart;
    logic                wake_hit;
    clk_plan_t           out_plan;

    pwr_mode_decode u_decode (
        .mode        (mode_lat),
        .timer2_async(timer2_async),
        .plan        (plan),
        .mask        (mask),
        .osc_restart (osc_restart)
    );

    pwr_wake_filter u_filter (
        .src     (wake_src),
        .mask    (mask),
        .wake_hit(wake_hit)
    );

    pwr_sleep_seq #(
        .STARTUP_W  (STARTUP_W),
        .HALT_CYCLES(HALT_CYCLES)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep_req     (sleep_req),
        .sleep_en      (cfg_q.sleep_en),
        .mode_in       (fold_mode(cfg_q.mode)),
        .wake_hit      (wake_hit),
        .wake_reset    (wake_reset),
        .osc_restart   (osc_restart),
        .startup_cycles(startup_cycles),
        .phase         (phase),
        .mode_lat      (mode_lat),
        .rst_seen      (rst_seen)
    );

    always_comb begin
        out_plan = PLAN_ALL_ON;
        case (phase)
            PH_SLEEP: out_plan = plan;
            PH_STARTUP: begin
                out_plan          = plan;
                out_plan.osc_main = 1'b1;
            end
            default: out_plan = PLAN_ALL_ON;
        endcase
    end

    assign cpu_clk_en   = out_plan.cpu;
    assign flash_clk_en = out_plan.flash;
    assign io_clk_en    = out_plan.io;
    assign adc_clk_en   = out_plan.adc;
    assign async_clk_en = out_plan.async_t;
    assign main_osc_en  = out_plan.osc_main;
    assign async_osc_en = out_plan.osc_async;

    assign asleep       = (phase == PH_SLEEP);
    assign core_stall   = (phase == PH_SLEEP) || (phase == PH_STARTUP) || (phase == PH_HALT);
    assign resume_valid = (phase == PH_RESUME);
    assign resume_reset = (phase == PH_RESUME) && rst_seen;

    // R3: core and flash clocks are off for the whole sleep
    a_r3_core_clock_off: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (!cpu_clk_en && !flash_clk_en));

    // R9: the main oscillator runs while the core waits to restart
    a_r9_osc_during_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (core_stall && !asleep) |-> main_osc_en);

    // R10: resume releases the core
    a_r10_resume_unstalled: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |-> !core_stall);

endmodule

// File: tb/pwr_sleep_ctrl_test.sv
module pwr_sleep_ctrl_test;

    localparam int SW = 16;
    localparam int S_DEF = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic          cfg_sleep_en = 1'b0;
    logic [2:0]    cfg_mode = 3'b000;
    logic          sleep_req = 1'b0;
    logic [9:0]    wake_src = '0;
    logic          timer2_async = 1'b0;
    logic          wake_reset = 1'b0;
    logic [SW-1:0] startup_cycles = SW'(S_DEF);
    logic cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, async_clk_en;
    logic main_osc_en, async_osc_en, asleep, core_stall, resume_valid, resume_reset;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_sleep_ctrl #(.STARTUP_W(SW), .HALT_CYCLES(4)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sleep_en(cfg_sleep_en),
        .cfg_mode(cfg_mode), .sleep_req(sleep_req), .wake_src(wake_src),
        .timer2_async(timer2_async), .wake_reset(wake_reset),
        .startup_cycles(startup_cycles), .cpu_clk_en(cpu_clk_en),
        .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en), .adc_clk_en(adc_clk_en),
        .async_clk_en(async_clk_en), .main_osc_en(main_osc_en),
        .async_osc_en(async_osc_en), .asleep(asleep), .core_stall(core_stall),
        .resume_valid(resume_valid), .resume_reset(resume_reset)
    );

    function automatic logic [6:0] gates();
        return {cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en,
                async_clk_en, main_osc_en, async_osc_en};
    endfunction

    function automatic int fold(input int m);
        return (m == 4 || m == 5) ? 0 : m;
    endfunction

    // expected {cpu,flash,io,adc,async,osc,aosc} per R4/R5
    function automatic logic [6:0] exp_plan(input int m, input logic a);
        case (fold(m))
            0: return 7'b0011111;
            1: return 7'b0001111;
            2: return 7'b0000000;
            3: return {4'b0000, a, 1'b0, a};
            6: return 7'b0000010;
            default: return {4'b0000, a, 1'b1, a};
        endcase
    endfunction

    // expected wake mask per R6/R7/R8
    function automatic logic [9:0] exp_mask(input int m, input logic a);
        logic [9:0] k;
        k = 10'b0010001101;
        case (fold(m))
            0: k = 10'b1111111111;
            1: k = k | 10'b0001100000 | {5'b0, a, 4'b0};
            2, 6: k = k | 10'b0100000000;
            default: k = k | 10'b0100000000 | {5'b0, a, 4'b0};
        endcase
        return k;
    endfunction

    function automatic bit osc_stops(input int m);
        return fold(m) == 2 || fold(m) == 3;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic en, input logic [2:0] m);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sleep_en = en; cfg_mode = m;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    // drive a wake stimulus for one cycle, then measure stall length to resume
    task automatic wake_run(input logic [9:0] src, input logic rst_in,
                            input logic rst_mid, output int stall_n,
                            output logic rr, output logic [6:0] g_res);
        int guard;
        @(negedge clk);
        wake_src = src; wake_reset = rst_in;
        @(negedge clk);
        wake_src = '0; wake_reset = 1'b0;
        stall_n = 0; guard = 0; rr = 1'b0; g_res = '0;
        while (!resume_valid && guard < 1000) begin
            if (core_stall && !asleep) stall_n++;
            if (rst_mid && stall_n == 2) wake_reset = 1'b1;
            else wake_reset = 1'b0;
            @(negedge clk);
            guard++;
        end
        wake_reset = 1'b0;
        rr = resume_reset;
        g_res = gates();
        chk("R10", "resume_unstalled", core_stall, 1'b0);
        @(negedge clk);
        chk("R10", "resume_one_cycle", resume_valid, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int sn;
        logic rr;
        logic [6:0] gr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "gates", gates(), 7'h7f);
        chk("R1", "asleep", asleep, 0);
        chk("R1", "stall", core_stall, 0);
        chk("R1", "resume", resume_valid, 0);

        // R2 disabled sleep
        set_cfg(1'b0, 3'b010);
        pulse_sleep();
        chk("R2", "asleep", asleep, 0);
        chk("R2", "gates", gates(), 7'h7f);
        @(negedge clk);
        chk("R2", "asleep_later", asleep, 0);

        // sweep: every mode code, both timer2 settings, every wake source
        for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < 2; a++) begin
                timer2_async = a[0];
                set_cfg(1'b1, 3'(m));
                for (int b = 0; b < 10; b++) begin
                    logic expw;
                    if (!asleep) begin
                        pulse_sleep();
                        chk("R3", "enter", asleep, 1);
                        chk((m == 4 || m == 5) ? "R5" : "R4", "plan", gates(),
                            exp_plan(m, a[0]));
                    end
                    expw = exp_mask(m, a[0])[b];
                    @(negedge clk);
                    wake_src = 10'(1) << b;
                    @(negedge clk);
                    wake_src = '0;
                    chk(b == 1 ? "R7" : (b == 4 ? "R8" : "R6"), "wake", !asleep, expw);
                    if (expw) begin
                        int guard;
                        sn = 0; guard = 0;
                        while (!resume_valid && guard < 1000) begin
                            if (core_stall && !asleep) sn++;
                            @(negedge clk);
                            guard++;
                        end
                        chk("R9", "stall_len", sn, osc_stops(m) ? S_DEF + 4 : 4);
                        chk("R10", "int_path", resume_reset, 0);
                        chk("R10", "all_on", gates(), 7'h7f);
                        @(negedge clk);
                        chk("R10", "one_cycle", resume_valid, 0);
                    end
                end
                if (asleep) begin
                    wake_run(10'b0000000001, 1'b0, 1'b0, sn, rr, gr);
                end
            end
        end

        // R9 zero start-up in power-down: only the halt remains
        timer2_async = 1'b0;
        startup_cycles = '0;
        set_cfg(1'b1, 3'b010);
        pulse_sleep();
        wake_run(10'b0010000000, 1'b0, 1'b0, sn, rr, gr);
        chk("R9", "zero_startup_len", sn, 4);
        startup_cycles = SW'(9);
        pulse_sleep();
        wake_run(10'b0010000000, 1'b0, 1'b0, sn, rr, gr);
        chk("R9", "startup9_len", sn, 13);

        // R11 reset with a simultaneous interrupt
        pulse_sleep();
        wake_run(10'b0000000100, 1'b1, 1'b0, sn, rr, gr);
        chk("R11", "reset_vector", rr, 1);
        chk("R11", "reset_all_on", gr, 7'h7f);
        // R11 reset alone in standby
        set_cfg(1'b1, 3'b110);
        pulse_sleep();
        wake_run(10'b0000000000, 1'b1, 1'b0, sn, rr, gr);
        chk("R11", "reset_only", rr, 1);
        chk("R11", "reset_only_len", sn, 4);
        // R11 reset arriving during start-up
        set_cfg(1'b1, 3'b010);
        pulse_sleep();
        wake_run(10'b0010000000, 1'b0, 1'b1, sn, rr, gr);
        chk("R11", "reset_mid_wake", rr, 1);
        // next interrupt wake is clean again
        pulse_sleep();
        wake_run(10'b0010000000, 1'b0, 1'b0, sn, rr, gr);
        chk("R10", "flag_cleared", rr, 0);

        // R12 config write while asleep is ignored
        startup_cycles = SW'(S_DEF);
        pulse_sleep();
        set_cfg(1'b1, 3'b000);
        chk("R12", "io_still_off", io_clk_en, 0);
        chk("R12", "osc_still_off", main_osc_en, 0);
        wake_run(10'b0010000000, 1'b0, 1'b0, sn, rr, gr);
        chk("R12", "latched_len", sn, S_DEF + 4);
        pulse_sleep();
        chk("R12", "new_mode_idle", gates(), 7'b0011111);
        wake_run(10'b1000000000, 1'b0, 1'b0, sn, rr, gr);
        chk("R12", "idle_len", sn, 4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule